// File: doc/BRIEF.md
# I2C Slave Address Recognizer

This block decides, for each address byte of an I2C transfer, whether the slave should answer. The bit-level receiver hands it whole received bytes with a one-cycle strobe. It also sends a one-cycle pulse on every START, repeated START or STOP. The recognizer compares each byte against a programmed 10-bit own address. A per-bit mask can turn any address bit into a don't-care. The result comes back as three one-cycle pulses: the ACK decision, an address hit and a general-call flag. The receiver uses the ACK decision to pull SDA low on the ninth clock, or to leave SDA released so the master sees NACK.

Both 7-bit and 10-bit addressing are supported. A 10-bit address phase takes two bytes, so a small state machine tracks where the transfer is. The states are:
- `S_ADDR1`: waiting for the first address byte.
- `S_ADDR2`: the first byte of a 10-bit address matched, and the low byte is expected.
- `S_IGNORE`: the address phase is decided, and bytes are ignored until the next restart pulse.

The transitions are:
- `ADDR1->ADDR2`: a 10-bit first byte matches.
- `ADDR1->IGNORE`: any other first byte.
- `ADDR2->IGNORE`: the low byte arrives.
- `any->ADDR1`: a restart pulse.

An accept-all control makes every comparison succeed, so the mask no longer matters. A general-call enable lets the all-zero write address be acknowledged and flagged separately from an own-address hit.

Top module: `i2c_addr_match`

## Requirements
- R1: A byte carries the 7-bit address in bits [7:1] and R/W in bit 0. In 7-bit mode (`ten_bit_i`=0) the address is compared with `own_addr_i[6:0]`. On a match, `ack_o` and `hit_o` pulse high for exactly one cycle, in the cycle after the `byte_vld_i` cycle.
- R2: In 10-bit mode the first byte must have bits [7:3]=11110 and bits [2:1]=`own_addr_i[9:8]`. A match gives `ack_o` alone and moves to `S_ADDR2`. The next byte is then compared with `own_addr_i[7:0]`, and a match gives `ack_o` and `hit_o`.
- R3: A 1 in bit i of `addr_mask_i` makes address bit i a don't-care in both modes. In 7-bit mode that covers bits 6..0. In 10-bit mode it covers bits 9..8 on the first byte and bits 7..0 on the second byte.
- R4: With `accept_all_i`=1 every comparison succeeds whatever the mask. In 7-bit mode any byte hits. In 10-bit mode the first byte gets ACK only and the second byte hits.
- R5: Byte 0x00 as the first address byte with `gcall_en_i`=1 gives `ack_o` and `gcall_o` and never `hit_o`, even if an own-address comparison also succeeds. Byte 0x01 is not a general call. With `gcall_en_i`=0, byte 0x00 is compared as an ordinary address.
- R6: Once the address phase is decided, further bytes get no response until a restart pulse. The phase is decided by a 7-bit byte, a general call, a 10-bit low byte or a failed 10-bit first byte.
- R7: A `restart_i` pulse returns the matcher to `S_ADDR1`. If `restart_i` and `byte_vld_i` are high in the same cycle, the byte is dropped and gets no response.
- R8: After reset all outputs are low and the next byte is treated as a first address byte.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous reset, active low |
| restart_i | input | 1 | One-cycle pulse on START, repeated START or STOP |
| byte_vld_i | input | 1 | Received byte strobe |
| byte_i | input | 8 | Received byte, bit 0 = R/W |
| own_addr_i | input | 10 | Programmed own address |
| addr_mask_i | input | 10 | Per-bit don't-care mask |
| ten_bit_i | input | 1 | 1 selects 10-bit addressing |
| gcall_en_i | input | 1 | Enables general-call recognition |
| accept_all_i | input | 1 | Accept every address, mask unused |
| ack_o | output | 1 | Drive ACK for the byte just received |
| hit_o | output | 1 | Own-address match complete |
| gcall_o | output | 1 | General call received |

## Verification
A single byte of 0x00 can satisfy both the general-call check and the own-address check. The bench provokes this in two ways: with `gcall_en_i` and `accept_all_i` both set, and in 10-bit mode with general call enabled. It then judges that `gcall_o` rises and `hit_o` stays low. A restart pulse can also land in the same cycle as a byte strobe. The bench drives both together, checks that no response follows, and checks that the next byte is still judged as a first address byte.

// File: rtl/i2c_addr_pkg.sv
package i2c_addr_pkg;
    parameter int ADDR_W  = 10;
    parameter int BYTE_W  = 8;
    parameter int SHORT_W = 7;
    localparam int HI_W   = ADDR_W - BYTE_W;
    localparam int PFX_W  = BYTE_W - HI_W - 1;
    localparam logic [PFX_W-1:0] TEN_PFX = 5'b11110;

    typedef enum logic [1:0] {
        S_ADDR1  = 2'd0,
        S_ADDR2  = 2'd1,
        S_IGNORE = 2'd2
    } match_state_t;
endpackage

// File: rtl/i2c_addr_cmp.sv
module i2c_addr_cmp
    import i2c_addr_pkg::*;
(
    input  logic [BYTE_W-1:0] byte_i,
    input  logic [ADDR_W-1:0] own_addr_i,
    input  logic [ADDR_W-1:0] addr_mask_i,
    input  logic              accept_all_i,
    input  logic              gcall_en_i,
    output logic              short_ok_o,
    output logic              hi_ok_o,
    output logic              lo_ok_o,
    output logic              gcall_ok_o
);
    // per-bit agreement of the byte against each address slice, mask forgives
    logic [SHORT_W-1:0] short_eq;
    logic [HI_W-1:0]    hi_eq;
    logic [BYTE_W-1:0]  lo_eq;

    genvar gi;
    generate
        for (gi = 0; gi < SHORT_W; gi++) begin : g_short
            assign short_eq[gi] = (byte_i[gi+1] == own_addr_i[gi]) | addr_mask_i[gi];
        end
        for (gi = 0; gi < HI_W; gi++) begin : g_hi
            assign hi_eq[gi] = (byte_i[gi+1] == own_addr_i[BYTE_W+gi]) | addr_mask_i[BYTE_W+gi];
        end
        for (gi = 0; gi < BYTE_W; gi++) begin : g_lo
            assign lo_eq[gi] = (byte_i[gi] == own_addr_i[gi]) | addr_mask_i[gi];
        end
    endgenerate

    logic pfx_ok;
    assign pfx_ok     = (byte_i[BYTE_W-1 -: PFX_W] == TEN_PFX);
    assign short_ok_o = accept_all_i | (&short_eq);
    assign hi_ok_o    = accept_all_i | (pfx_ok & (&hi_eq));
    assign lo_ok_o    = accept_all_i | (&lo_eq);
    assign gcall_ok_o = gcall_en_i & (byte_i == '0);
endmodule

// File: rtl/i2c_addr_fsm.sv
module i2c_addr_fsm
    import i2c_addr_pkg::*;
(
    input  logic clk,
    input  logic rst_n,
    input  logic restart_i,
    input  logic byte_vld_i,
    input  logic ten_bit_i,
    input  logic short_ok_i,
    input  logic hi_ok_i,
    input  logic lo_ok_i,
    input  logic gcall_ok_i,
    output logic ack_o,
    output logic hit_o,
    output logic gcall_o
);
    match_state_t state, state_nxt;
    logic ack_d, hit_d, gc_d;

    // next-state decision
    always_comb begin
        state_nxt = state;
        if (restart_i) begin
            state_nxt = S_ADDR1;
        end else if (byte_vld_i) begin
            unique case (state)
                S_ADDR1: begin
                    if (!gcall_ok_i && ten_bit_i && hi_ok_i) state_nxt = S_ADDR2;
                    else                                     state_nxt = S_IGNORE;
                end
                S_ADDR2:  state_nxt = S_IGNORE;
                S_IGNORE: state_nxt = S_IGNORE;
                default:  state_nxt = S_IGNORE;
            endcase
        end
    end

    // response decision for the byte in flight
    always_comb begin
        ack_d = 1'b0;
        hit_d = 1'b0;
        gc_d  = 1'b0;
        if (!restart_i && byte_vld_i) begin
            unique case (state)
                S_ADDR1: begin
                    if (gcall_ok_i) begin
                        ack_d = 1'b1;
                        gc_d  = 1'b1;
                    end else if (!ten_bit_i) begin
                        ack_d = short_ok_i;
                        hit_d = short_ok_i;
                    end else begin
                        ack_d = hi_ok_i;
                    end
                end
                S_ADDR2: begin
                    ack_d = lo_ok_i;
                    hit_d = lo_ok_i;
                end
                S_IGNORE: ;
                default: ;
            endcase
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) state <= S_ADDR1;
        else        state <= state_nxt;
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            ack_o   <= 1'b0;
            hit_o   <= 1'b0;
            gcall_o <= 1'b0;
        end else begin
            ack_o   <= ack_d;
            hit_o   <= hit_d;
            gcall_o <= gc_d;
        end
    end

    // a hit and a general call never coexist
    assert_gcall_excl_R5: assert property (@(posedge clk) disable iff (!rst_n)
        !(hit_o && gcall_o));
    // every positive result is acknowledged
    assert_hit_acked_R1: assert property (@(posedge clk) disable iff (!rst_n)
        (hit_o || gcall_o) |-> ack_o);
    // a response only follows an accepted byte strobe
    assert_resp_follows_byte_R1: assert property (@(posedge clk) disable iff (!rst_n)
        ack_o |-> $past(byte_vld_i && !restart_i));
    // restart returns to first-byte state with no response
    assert_restart_home_R7: assert property (@(posedge clk) disable iff (!rst_n)
        restart_i |=> (state == S_ADDR1) && !ack_o);
    // bytes after the decision are silent
    assert_ignore_silent_R6: assert property (@(posedge clk) disable iff (!rst_n)
        (state == S_IGNORE && byte_vld_i && !restart_i) |=> !ack_o);
    // low-byte state only entered from the first-byte state
    assert_addr2_entry_R2: assert property (@(posedge clk) disable iff (!rst_n)
        (state == S_ADDR2 && !$past(state == S_ADDR2)) |-> $past(state == S_ADDR1 && ten_bit_i));
endmodule

// File: rtl/i2c_addr_match.sv
module i2c_addr_match
    import i2c_addr_pkg::*;
(
    input  logic              clk,
    input  logic              rst_n,
    input  logic              restart_i,
    input  logic              byte_vld_i,
    input  logic [BYTE_W-1:0] byte_i,
    input  logic [ADDR_W-1:0] own_addr_i,
    input  logic [ADDR_W-1:0] addr_mask_i,
    input  logic              ten_bit_i,
    input  logic              gcall_en_i,
    input  logic              accept_all_i,
    output logic              ack_o,
    output logic              hit_o,
    output logic              gcall_o
);
    logic short_ok, hi_ok, lo_ok, gcall_ok;

    i2c_addr_cmp u_cmp (
        .byte_i       (byte_i),
        .own_addr_i   (own_addr_i),
        .addr_mask_i  (addr_mask_i),
        .accept_all_i (accept_all_i),
        .gcall_en_i   (gcall_en_i),
        .short_ok_o   (short_ok),
        .hi_ok_o      (hi_ok),
        .lo_ok_o      (lo_ok),
        .gcall_ok_o   (gcall_ok)
    );

    i2c_addr_fsm u_fsm (
        .clk        (clk),
        .rst_n      (rst_n),
        .restart_i  (restart_i),
        .byte_vld_i (byte_vld_i),
        .ten_bit_i  (ten_bit_i),
        .short_ok_i (short_ok),
        .hi_ok_i    (hi_ok),
        .lo_ok_i    (lo_ok),
        .gcall_ok_i (gcall_ok),
        .ack_o      (ack_o),
        .hit_o      (hit_o),
        .gcall_o    (gcall_o)
    );
endmodule

// File: tb/i2c_addr_match_tb_top.sv
module i2c_addr_match_tb_top;
    logic       clk = 1'b0;
    logic       rst_n = 1'b0;
    logic       restart_i = 1'b0;
    logic       byte_vld_i = 1'b0;
    logic [7:0] byte_i = 8'h00;
    logic [9:0] own_addr_i = 10'h000;
    logic [9:0] addr_mask_i = 10'h000;
    logic       ten_bit_i = 1'b0;
    logic       gcall_en_i = 1'b0;
    logic       accept_all_i = 1'b0;
    logic       ack_o, hit_o, gcall_o;

    int checks = 0;
    int failures = 0;
    bit done = 1'b0;

    always #5 clk = ~clk;

    i2c_addr_match dut_i (.*);

    typedef struct packed {
        logic       ten, gen, all;
        logic [9:0] own, mask;
        logic [7:0] b1;
        logic       two;
        logic [7:0] b2;
        logic [2:0] e1, e2;   // {ack, hit, gcall}
        logic [3:0] req;
    } vec_t;

    localparam int NV = 16;
    localparam vec_t VECS [NV] = '{
        '{1'b0,1'b0,1'b0,10'h02A,10'h000,8'h54,1'b0,8'h00,3'b110,3'b000,4'd1}, // R1 hit
        '{1'b0,1'b0,1'b0,10'h02A,10'h000,8'h56,1'b0,8'h00,3'b000,3'b000,4'd1}, // R1 miss
        '{1'b0,1'b0,1'b0,10'h000,10'h020,8'h40,1'b0,8'h00,3'b110,3'b000,4'd3}, // R3 bit5 free
        '{1'b0,1'b0,1'b0,10'h000,10'h020,8'h00,1'b0,8'h00,3'b110,3'b000,4'd5}, // R5 0x00 plain
        '{1'b0,1'b1,1'b0,10'h02A,10'h000,8'h00,1'b0,8'h00,3'b101,3'b000,4'd5}, // R5 gcall
        '{1'b0,1'b1,1'b0,10'h02A,10'h000,8'h01,1'b0,8'h00,3'b000,3'b000,4'd5}, // R5 read not gcall
        '{1'b1,1'b0,1'b0,10'h2A5,10'h000,8'hF4,1'b1,8'hA5,3'b100,3'b110,4'd2}, // R2 hit
        '{1'b1,1'b0,1'b0,10'h2A5,10'h000,8'hF4,1'b1,8'hA4,3'b100,3'b000,4'd2}, // R2 low miss
        '{1'b1,1'b0,1'b0,10'h2A5,10'h000,8'hF2,1'b1,8'hA5,3'b000,3'b000,4'd6}, // R6 hi miss
        '{1'b1,1'b0,1'b0,10'h2A5,10'h300,8'hF2,1'b1,8'hA5,3'b100,3'b110,4'd3}, // R3 hi mask
        '{1'b1,1'b0,1'b0,10'h2A5,10'h001,8'hF4,1'b1,8'hA4,3'b100,3'b110,4'd3}, // R3 lo mask
        '{1'b0,1'b0,1'b1,10'h02A,10'h000,8'h10,1'b0,8'h00,3'b110,3'b000,4'd4}, // R4 7-bit
        '{1'b1,1'b0,1'b1,10'h2A5,10'h000,8'h12,1'b1,8'h33,3'b100,3'b110,4'd4}, // R4 10-bit
        '{1'b0,1'b1,1'b1,10'h02A,10'h000,8'h00,1'b0,8'h00,3'b101,3'b000,4'd5}, // R5 vs accept-all
        '{1'b1,1'b1,1'b0,10'h2A5,10'h000,8'h00,1'b1,8'hA5,3'b101,3'b000,4'd5}, // R5 10-bit gcall
        '{1'b0,1'b0,1'b0,10'h3FF,10'h000,8'hFE,1'b0,8'h00,3'b110,3'b000,4'd1}  // R1 upper bits unused
    };

    task automatic check(input string tag, input logic [2:0] exp);
        checks++;
        if ({ack_o, hit_o, gcall_o} !== exp) begin
            failures++;
            $display("FAIL %s: got ack/hit/gc=%b expected %b", tag, {ack_o, hit_o, gcall_o}, exp);
        end
    endtask

    task automatic pulse_restart();
        @(negedge clk) restart_i = 1'b1;
        @(negedge clk) restart_i = 1'b0;
    endtask

    task automatic send(input logic [7:0] b);
        @(negedge clk) begin byte_vld_i = 1'b1; byte_i = b; end
        @(negedge clk) byte_vld_i = 1'b0;
    endtask

    initial begin
        repeat (3) @(negedge clk);
        check("R8 reset outputs", 3'b000);
        rst_n = 1'b1;
        // R8: first byte after reset is an address byte
        own_addr_i = 10'h02A;
        send(8'h54);
        check("R8 first byte after reset", 3'b110);
        @(negedge clk);
        check("R1 single-cycle pulse", 3'b000);

        for (int i = 0; i < NV; i++) begin
            @(negedge clk);
            ten_bit_i = VECS[i].ten; gcall_en_i = VECS[i].gen; accept_all_i = VECS[i].all;
            own_addr_i = VECS[i].own; addr_mask_i = VECS[i].mask;
            pulse_restart();
            send(VECS[i].b1);
            check($sformatf("R%0d vec %0d byte1", VECS[i].req, i), VECS[i].e1);
            if (VECS[i].two) begin
                send(VECS[i].b2);
                check($sformatf("R%0d vec %0d byte2", VECS[i].req, i), VECS[i].e2);
            end
        end

        // R6: byte after a 7-bit match is ignored
        ten_bit_i = 1'b0; gcall_en_i = 1'b0; accept_all_i = 1'b0;
        own_addr_i = 10'h02A; addr_mask_i = 10'h000;
        pulse_restart();
        send(8'h54);
        check("R6 addr byte", 3'b110);
        send(8'h54);
        check("R6 following byte ignored", 3'b000);

        // R7: restart between 10-bit bytes re-arms the first-byte check
        ten_bit_i = 1'b1; own_addr_i = 10'h2A5;
        pulse_restart();
        send(8'hF4);
        check("R7 hi byte", 3'b100);
        pulse_restart();
        send(8'hA5);
        check("R7 low byte judged as first byte", 3'b000);

        // R7: restart and strobe in the same cycle
        ten_bit_i = 1'b0; own_addr_i = 10'h02A;
        @(negedge clk) begin restart_i = 1'b1; byte_vld_i = 1'b1; byte_i = 8'h54; end
        @(negedge clk) begin restart_i = 1'b0; byte_vld_i = 1'b0; end
        check("R7 colliding byte dropped", 3'b000);
        send(8'h54);
        check("R7 next byte is first byte", 3'b110);

        // R8: reset mid 10-bit phase
        ten_bit_i = 1'b1; own_addr_i = 10'h2A5;
        pulse_restart();
        send(8'hF4);
        @(negedge clk) rst_n = 1'b0;
        @(negedge clk) rst_n = 1'b1;
        check("R8 outputs low after reset", 3'b000);
        send(8'hA5);
        check("R8 state back to first byte", 3'b000);

        done = 1'b1;
        $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
        $finish;
    end

    initial begin
        repeat (20000) @(posedge clk);
        if (!done) begin
            failures++;
            $display("FAIL watchdog: got timeout expected completion");
            $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
            $finish;
        end
    end
endmodule